// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that lets an external bus controller read and write a bank of byte-wide registers. A fast system clock oversamples both bus lines. Each line passes through a two-stage synchronizer and a persistence filter, and the block then detects start, repeated start and stop conditions on the filtered lines. The 7-bit device address comes from two strap inputs. The mapping from strap values to addresses is not sequential.

In a write transfer, the first byte after the address sets an internal register pointer. Every following byte is stored at the pointer, and the pointer then steps forward. A read is done by writing the pointer, issuing a repeated start and sending the address with the read bit set. The block then returns bytes from successive registers until the controller declines a byte. The pointer wraps from the highest register back to zero. The block only ever pulls SDA low; the `sda_oe` output drives an open-drain pad. It has no output on SCL, so it can never stretch the clock.

The register file sits outside the block. It sees a pointer address, write data and a one-cycle write strobe, and it returns read data combinationally for the current address.

Top module: `i2c_reg_target`

## Requirements
- R1: While reset is held and directly after it is released, `sda_oe` is 0, `reg_we` is 0 and `reg_addr` is 0.
- R2: The device address is 0x1E for strap {sa1,sa0}=00, 0x1D for 01, 0x1C for 10 and 0x1F for 11. After a start, the block acknowledges an address byte (7 address bits MSB first, then R/W with 0=write, 1=read) whose address matches.
- R3: When the address does not match, the block never pulls SDA low and never pulses `reg_we` until the next start or stop.
- R4: In a write transfer, the first data byte loads the register pointer without a write. Each later byte pulses `reg_we` once with that byte at the pointer address, and the block acknowledges every byte.
- R5: The pointer advances by one after each byte written or transmitted, and it wraps from 2^REG_AW-1 to 0.
- R6: After a repeated start with the read bit set, the block sends bytes MSB first, starting at the pointer. While the controller acknowledges, the block keeps returning successive registers.
- R7: After the controller does not acknowledge a read byte, the block leaves SDA released through any further clocks until a stop or a start.
- R8: `sda_oe` changes only while SCL is low, except on a start or stop. An acknowledge stays low for the whole SCL high phase.
- R9: A pulse on SCL or SDA shorter than FILT_LEN system clocks has no effect on the transfer.
- R10: A stop returns the block to idle. A repeated start at any point restarts address reception, so a pointer byte sent before it causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_sa1 | input | 1 | Address strap, high select |
| strap_sa0 | input | 1 | Address strap, low select |
| reg_addr | output | REG_AW | Register pointer presented to the register file |
| reg_wdata | output | 8 | Byte to store |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr` |

## Verification
The hardest states to reach from the ports are the ones that follow an unusual controller action. One is the quiet state after a declined read byte. Another is a repeated start that cuts short a write whose pointer has just been loaded. A third is a bus glitch too short to count. The stimulus reaches the first by declining a byte and then clocking one more full byte, which must read back as all ones. It reaches the second by restarting right after the pointer byte and then reading back the register that byte named. For the glitches, a write is replayed in which every bit carries a short SCL pulse in its low phase and a short SDA inversion in its high phase; the stored byte must come out intact.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_IGN
  } tgt_state_e;

  // strap pair to 7-bit device address (non-sequential mapping)
  function automatic logic [6:0] strap_addr(input logic sa1, input logic sa0);
    logic [6:0] a;
    case ({sa1, sa0})
      2'b00:   a = 7'h1E;
      2'b01:   a = 7'h1D;
      2'b10:   a = 7'h1C;
      default: a = 7'h1F;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT = 4,
  localparam int CW = $clog2(FILT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == out_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT - 1)) begin
        out_q <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign line_o = out_q;

  // R9
  filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> ($past(sync_q[1]) == out_q));

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter int REG_AW   = 4,
  parameter int FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              strap_sa1,
  input  logic              strap_sa0,
  output logic [REG_AW-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              reg_we,
  input  logic [7:0]        reg_rdata
);

  localparam int LINES = 2;

  logic [LINES-1:0] raw_lines, filt_lines;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_filt
    i2c_line_filter #(.FILT(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_lines[g]),
      .line_o (filt_lines[g])
    );
  end

  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  i2c_cond_detect u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .sda_f     (sda_f),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tgt_state_e          state_q;
  logic [3:0]          cnt_q;
  logic [BYTE_W-1:0]   shreg_q, txsh_q;
  logic [REG_AW-1:0]   ptr_q;
  logic                rw_q, addr_phase_q, ptr_phase_q, nack_q;

  logic [6:0] dev_addr;
  logic       addr_match, byte_done, wr_fire, tx_done;

  assign dev_addr   = strap_addr(strap_sa1, strap_sa0);
  assign addr_match = (shreg_q[7:1] == dev_addr);
  assign byte_done  = (state_q == ST_RX) && scl_fall && (cnt_q == 4'd8);
  assign wr_fire    = byte_done && !addr_phase_q && !ptr_phase_q;
  assign tx_done    = (state_q == ST_TX) && scl_fall && (cnt_q == 4'd7);

  assign reg_addr  = ptr_q;
  assign reg_wdata = shreg_q;
  assign reg_we    = wr_fire;
  assign sda_oe    = (state_q == ST_ACK) || ((state_q == ST_TX) && !txsh_q[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      shreg_q      <= '0;
      txsh_q       <= '1;
      ptr_q        <= '0;
      rw_q         <= 1'b0;
      addr_phase_q <= 1'b0;
      ptr_phase_q  <= 1'b0;
      nack_q       <= 1'b0;
    end else if (start_det) begin
      state_q      <= ST_RX;
      cnt_q        <= '0;
      addr_phase_q <= 1'b1;
      ptr_phase_q  <= 1'b0;
    end else if (stop_det) begin
      state_q      <= ST_IDLE;
      addr_phase_q <= 1'b0;
      ptr_phase_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise && cnt_q != 4'd8) begin
            shreg_q <= {shreg_q[6:0], sda_f};
            cnt_q   <= cnt_q + 4'd1;
          end else if (byte_done) begin
            if (addr_phase_q) begin
              if (addr_match) begin
                rw_q         <= shreg_q[0];
                ptr_phase_q  <= !shreg_q[0];
                addr_phase_q <= 1'b0;
                state_q      <= ST_ACK;
              end else begin
                state_q <= ST_IGN;
              end
            end else begin
              if (ptr_phase_q) begin
                ptr_q       <= shreg_q[REG_AW-1:0];
                ptr_phase_q <= 1'b0;
              end else begin
                ptr_q <= ptr_q + REG_AW'(1);
              end
              state_q <= ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              txsh_q  <= reg_rdata;
              state_q <= ST_TX;
            end else begin
              state_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (tx_done) begin
            ptr_q   <= ptr_q + REG_AW'(1);
            txsh_q  <= '1;
            state_q <= ST_MACK;
          end else if (scl_fall) begin
            txsh_q <= {txsh_q[6:0], 1'b1};
            cnt_q  <= cnt_q + 4'd1;
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            nack_q <= sda_f;
          end else if (scl_fall) begin
            if (nack_q) begin
              state_q <= ST_IGN;
            end else begin
              txsh_q  <= reg_rdata;
              cnt_q   <= '0;
              state_q <= ST_TX;
            end
          end
        end
        default: state_q <= state_q;
      endcase
    end
  end

  // R8
  oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_f || $past(start_det) || $past(stop_det)));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire || tx_done) && !start_det && !stop_det |=> (ptr_q == $past(ptr_q) + REG_AW'(1)));

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (state_q == ST_IDLE));

  // R3
  ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGN && !start_det) |=> (!sda_oe && !reg_we));

  // R2
  ack_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK) && ($past(state_q) == ST_RX) && $past(addr_phase_q) |-> $past(addr_match));

endmodule

// File: tb/i2c_reg_target_bench.sv
module i2c_reg_target_bench;

  localparam int CLK_P = 10;
  localparam int Q     = 25;
  localparam int AW    = 4;
  localparam int NREG  = 1 << AW;

  // {straps, pointer, byte0, byte1}
  localparam logic [21:0] VEC [4] = '{
    {2'd0, 4'h3, 8'hA5, 8'h3C},
    {2'd1, 4'h0, 8'h01, 8'hFF},
    {2'd2, 4'h9, 8'h80, 8'h7E},
    {2'd3, 4'hF, 8'h55, 8'hAA}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sa1 = 1'b0, sa0 = 1'b0;
  logic sda_oe, reg_we;
  logic [AW-1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic sda_line;

  logic [7:0] mem [NREG];
  logic [7:0] exp_mem [NREG];

  int n_chk = 0, n_fail = 0;
  int we_cnt = 0, oe_cnt = 0, viol = 0;
  logic scl_prev = 1'b1, oe_prev = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_reg_target #(.REG_AW(AW), .FILT_LEN(4)) u_i2c_reg_target (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .strap_sa1 (sa1),
    .strap_sa0 (sa0),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= 8'h40 + 8'(i);
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  // port monitor, sampled on the inactive edge (R8, R3 counters)
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe != oe_prev && scl_m && scl_prev) viol++;
      if (reg_we) we_cnt++;
      if (sda_oe) oe_cnt++;
    end
    scl_prev = scl_m;
    oe_prev  = sda_oe;
  end

  function automatic logic [6:0] bench_addr(input logic [1:0] s);
    case (s)
      2'd2:    return 7'h1C;
      2'd1:    return 7'h1D;
      2'd0:    return 7'h1E;
      default: return 7'h1F;
    endcase
  endfunction

  task automatic tick(input int n);
    #(n * CLK_P);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack, input bit glitch);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      if (glitch) begin scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(Q); end
      scl_m = 1'b1; tick(Q);
      if (glitch) begin sda_m = ~b[i]; tick(2); sda_m = b[i]; tick(Q); end
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(2);
    a1 = !sda_line; tick(Q - 4);
    a2 = !sda_line; tick(2);
    scl_m = 1'b0; tick(Q);
    ack = a1 && a2;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q/2);
      b[i] = sda_line; tick(Q - Q/2);
      scl_m = 1'b0;
    end
    tick(Q);
    sda_m = mack ? 1'b0 : 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] rb0, rb1, rb2, rb3;
    logic [1:0] s;
    logic [3:0] p, p1, p2;
    logic [7:0] d0, d1;
    logic [6:0] a;
    int w0, o0;

    for (int i = 0; i < NREG; i++) exp_mem[i] = 8'h40 + 8'(i);
    @(negedge clk); #1;
    tick(5);
    // R1: held in reset
    chk(!sda_oe && !reg_we && reg_addr == '0, "R1 in reset", {sda_oe, reg_we, reg_addr}, 0);
    rst_n = 1'b1; tick(3);
    chk(!sda_oe && !reg_we && reg_addr == '0, "R1 after reset", {sda_oe, reg_we, reg_addr}, 0);

    // table walk: burst write two bytes, read them back (R2 R4 R5 R6)
    for (int v = 0; v < 4; v++) begin
      {s, p, d0, d1} = VEC[v];
      {sa1, sa0} = s;
      a  = bench_addr(s);
      p1 = p + 4'd1;
      tick(4);
      bus_start();
      send_byte({a, 1'b0}, ack, 0); chk(ack, "R2 address ack", ack, 1);
      send_byte({4'h0, p}, ack, 0); chk(ack, "R4 pointer ack", ack, 1);
      send_byte(d0, ack, 0);        chk(ack, "R4 data0 ack", ack, 1);
      send_byte(d1, ack, 0);        chk(ack, "R4 data1 ack", ack, 1);
      bus_stop();
      exp_mem[p] = d0; exp_mem[p1] = d1;
      chk(mem[p] == d0, "R4 stored at pointer", mem[p], d0);
      chk(mem[p1] == d1, "R5 stored at next (wrapping) pointer", mem[p1], d1);
      bus_start();
      send_byte({a, 1'b0}, ack, 0);
      send_byte({4'h0, p}, ack, 0);
      bus_rstart();
      send_byte({a, 1'b1}, ack, 0); chk(ack, "R6 read address ack", ack, 1);
      recv_byte(rb0, 1'b1);
      recv_byte(rb1, 1'b0);
      bus_stop();
      chk(rb0 == d0, "R6 read byte0", rb0, d0);
      chk(rb1 == d1, "R6 read byte1", rb1, d1);
    end

    // R3: wrong address is ignored
    {sa1, sa0} = 2'b00;
    tick(4);
    w0 = we_cnt; o0 = oe_cnt;
    bus_start();
    send_byte({7'h1D, 1'b0}, ack, 0); chk(!ack, "R3 mismatch not acked", ack, 0);
    send_byte(8'h02, ack, 0);
    send_byte(8'h99, ack, 0);         chk(!ack, "R3 data not acked", ack, 0);
    bus_stop();
    chk(we_cnt == w0, "R3 no write strobe", we_cnt - w0, 0);
    chk(oe_cnt == o0, "R3 SDA never pulled", oe_cnt - o0, 0);

    // R10: repeated start after pointer byte restarts address phase
    a = bench_addr(2'b00);
    bus_start();
    send_byte({a, 1'b0}, ack, 0);
    send_byte(8'h05, ack, 0);
    bus_rstart();
    send_byte({a, 1'b0}, ack, 0); chk(ack, "R10 address after restart", ack, 1);
    send_byte(8'h06, ack, 0);
    send_byte(8'h42, ack, 0);
    bus_stop();
    exp_mem[6] = 8'h42;
    bus_start();
    send_byte({a, 1'b0}, ack, 0);
    send_byte(8'h05, ack, 0);
    bus_rstart();
    send_byte({a, 1'b1}, ack, 0);
    recv_byte(rb0, 1'b1);
    recv_byte(rb1, 1'b0);
    bus_stop();
    chk(rb0 == exp_mem[5], "R10 pointer byte caused no write", rb0, exp_mem[5]);
    chk(rb1 == 8'h42, "R10 write after restart", rb1, 8'h42);

    // R7 + read wrap: three bytes from 0xE, decline, then one more byte
    p = 4'hE; p1 = 4'hF; p2 = 4'h0;
    bus_start();
    send_byte({a, 1'b0}, ack, 0);
    send_byte({4'h0, p}, ack, 0);
    bus_rstart();
    send_byte({a, 1'b1}, ack, 0);
    recv_byte(rb0, 1'b1);
    recv_byte(rb1, 1'b1);
    recv_byte(rb2, 1'b0);
    o0 = oe_cnt;
    recv_byte(rb3, 1'b0);
    bus_stop();
    chk(rb0 == exp_mem[p] && rb1 == exp_mem[p1], "R6 burst sequence", {rb0, rb1}, {exp_mem[p], exp_mem[p1]});
    chk(rb2 == exp_mem[p2], "R5 read pointer wraps", rb2, exp_mem[p2]);
    chk(rb3 == 8'hFF, "R7 released after decline", rb3, 8'hFF);
    chk(oe_cnt == o0, "R7 no drive after decline", oe_cnt - o0, 0);

    // R9: short glitches on both lines during a write
    bus_start();
    send_byte({a, 1'b0}, ack, 0);
    send_byte(8'h07, ack, 0);
    send_byte(8'hC3, ack, 1); chk(ack, "R9 glitched byte acked", ack, 1);
    bus_stop();
    chk(mem[7] == 8'hC3, "R9 glitched byte stored", mem[7], 8'hC3);

    // R8: drive changes only in SCL low phase; acks held through high
    chk(viol == 0, "R8 SDA changed during SCL high", viol, 0);

    tick(10);
    finish_run();
  end

endmodule